// File: doc/BRIEF.md
# Composite Clock AMI Encoder

This block turns a 64 kHz bit-rate enable into a bipolar composite clock stream. Every bit period it fires exactly one pulse on either a positive or a negative output. Consecutive pulses normally swap polarity, so the stream has no DC content. The 8 kHz octet phase rides inside the same stream: on the bit period marked by the frame strobe, the polarity does not swap. A receiver sees two same-sign pulses in a row and recovers the octet boundary from that bipolar violation.

The block runs from a fast system clock. A one-cycle bit enable, phase-aligned to 64 kHz, marks the start of each bit period, and a frame strobe that coincides with that enable marks the first bit of each octet, once every eight bit periods. The pulse length in system clocks comes from a configuration input. The block forces that length into the allowed duty window of 50 % to 70 % of the bit period, so a bad setting can never produce an out-of-range mark. After reset the block stays silent until it sees the first frame strobe, so the first pulse it emits is already octet-aligned.

Top module: `cc_ami_enc`

## Requirements
- R1: After reset both outputs are low, and they stay low, whatever the bit enable does, until a bit enable arrives together with a frame strobe.
- R2: The first pulse after alignment is positive (out_pos) and starts in the cycle after the edge that samples bit_en and frame_stb both high.
- R3: On a bit enable without frame strobe, once aligned, the pulse has the opposite polarity to the previous pulse.
- R4: On a bit enable with frame strobe, once aligned, the pulse repeats the polarity of the previous pulse (the violation), and later pulses alternate again from that polarity.
- R5: A pulse stays high for exactly width_cfg system clocks when width_cfg lies inside the window [ceil(0.5*PERIOD_CLKS), floor(0.7*PERIOD_CLKS)]; both window limits themselves pass unchanged.
- R6: A width_cfg below the lower window limit gives a pulse of the lower limit.
- R7: A width_cfg above the upper window limit gives a pulse of the upper limit.
- R8: out_pos and out_neg are never high in the same cycle, and both are low between pulses.
- R9: A frame strobe without a bit enable in the same cycle has no effect: it neither aligns the block nor alters the polarity sequence.
- R10: The pulse length is taken when the pulse starts; a change of width_cfg during a pulse does not alter that pulse. width_cfg must be stable for two cycles before a bit enable to apply to its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe at the start of each 64 kHz bit period |
| frame_stb | input | 1 | Octet boundary marker, valid only together with bit_en |
| width_cfg | input | CNT_W | Requested pulse length in system clocks |
| out_pos | output | 1 | Positive pulse output, registered |
| out_neg | output | 1 | Negative pulse output, registered |

## Verification
Two functions share a cycle: the start of an ordinary pulse and the octet violation both fall on a bit enable. When frame_stb is high in that cycle, the polarity rule flips from "swap" to "repeat". The bench provokes this at the end of a full octet and at alignment, then judges it by the sign of that pulse and of the pulse after it. The second collision is a width change that lands inside a running pulse. The bench checks it by measuring that pulse at the old length and the next pulse at the new length. Stray strobes that come without an enable are also driven, to show that they leave both the alignment and the sequence untouched.

// File: rtl/cc_ami_pkg.sv
package cc_ami_pkg;

  // Lower duty limit: 50 % of the bit period, rounded up
  function automatic int win_lo(input int period);
    return (period * 50 + 99) / 100;
  endfunction

  // Upper duty limit: 70 % of the bit period, rounded down
  function automatic int win_hi(input int period);
    return (period * 70) / 100;
  endfunction

  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;

endpackage

// File: rtl/cc_width_clamp.sv
module cc_width_clamp
  import cc_ami_pkg::*;
#(
  parameter int PERIOD_CLKS = 781,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] width_cfg,
  output logic [CNT_W-1:0] width_eff
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(win_lo(PERIOD_CLKS));
  localparam logic [CNT_W-1:0] HI = CNT_W'(win_hi(PERIOD_CLKS));

  logic [CNT_W-1:0] clamped;

  always_comb begin
    if (width_cfg < LO)      clamped = LO;
    else if (width_cfg > HI) clamped = HI;
    else                     clamped = width_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) width_eff <= LO;
    else     width_eff <= clamped;
  end
endmodule

// File: rtl/cc_polarity_seq.sv
module cc_polarity_seq
  import cc_ami_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic frame_stb,
  output logic fire,
  output pol_e pol_now
);
  logic aligned;
  pol_e last_pol;

  always_comb begin
    fire = bit_en && (aligned || frame_stb);
    if (frame_stb) pol_now = aligned ? last_pol : POL_POS;
    else           pol_now = (last_pol == POL_POS) ? POL_NEG : POL_POS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned  <= 1'b0;
      last_pol <= POL_NEG;
    end else if (fire) begin
      aligned  <= 1'b1;
      last_pol <= pol_now;
    end
  end
endmodule

// File: rtl/cc_pulse_drv.sv
module cc_pulse_drv
  import cc_ami_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  pol_e             pol_now,
  input  logic [CNT_W-1:0] width_eff,
  output logic [1:0]       lanes
);
  logic [CNT_W-1:0] remain;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
    end else if (fire) begin
      remain <= width_eff - CNT_W'(1);
      busy   <= 1'b1;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - CNT_W'(1);
    end
  end

  // lane 0 = positive, lane 1 = negative
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                        lanes[g] <= 1'b0;
      else if (fire)                  lanes[g] <= (pol_now == pol_e'(g));
      else if (busy && remain == '0)  lanes[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_ami_enc.sv
module cc_ami_enc
  import cc_ami_pkg::*;
#(
  parameter int PERIOD_CLKS = 781,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             frame_stb,
  input  logic [CNT_W-1:0] width_cfg,
  output logic             out_pos,
  output logic             out_neg
);
  logic [CNT_W-1:0] width_eff;
  logic             fire;
  pol_e             pol_now;
  logic [1:0]       lanes;

  cc_width_clamp #(.PERIOD_CLKS(PERIOD_CLKS), .CNT_W(CNT_W)) u_clamp (
    .clk(clk), .rst(rst), .width_cfg(width_cfg), .width_eff(width_eff)
  );

  cc_polarity_seq u_pol (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_stb(frame_stb),
    .fire(fire), .pol_now(pol_now)
  );

  cc_pulse_drv #(.CNT_W(CNT_W)) u_drv (
    .clk(clk), .rst(rst), .fire(fire), .pol_now(pol_now),
    .width_eff(width_eff), .lanes(lanes)
  );

  assign out_pos = lanes[0];
  assign out_neg = lanes[1];
endmodule

// File: rtl/cc_ami_chk.sv
module cc_ami_chk
  import cc_ami_pkg::*;
#(
  parameter int PERIOD_CLKS = 781,
  parameter int CNT_W       = 10
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic frame_stb,
  input logic out_pos,
  input logic out_neg
);
  localparam int LO = win_lo(PERIOD_CLKS);
  localparam int HI = win_hi(PERIOD_CLKS);

  logic             seen_q;
  logic [CNT_W-1:0] run_q;
  logic             act;

  assign act = out_pos || out_neg;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      if (bit_en && frame_stb) seen_q <= 1'b1;
      run_q <= act ? run_q + CNT_W'(1) : '0;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_pos && out_neg));                                    // R8

  AST_IDLE_UNALIGNED: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !act);                                         // R1

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (bit_en && (frame_stb || seen_q)) |=> act);                // R2

  AST_WIDTH_MAX: assert property (@(posedge clk) disable iff (rst)
    act |-> (int'(run_q) < HI));                               // R7

  AST_WIDTH_MIN: assert property (@(posedge clk) disable iff (rst)
    (!act && run_q != '0) |-> (int'(run_q) >= LO));            // R6
endmodule

bind cc_ami_enc cc_ami_chk #(.PERIOD_CLKS(PERIOD_CLKS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .frame_stb(frame_stb),
  .out_pos(out_pos), .out_neg(out_neg)
);

// File: tb/tb_cc_ami_enc.sv
module tb_cc_ami_enc;
  localparam int PER = 20;
  localparam int CW  = 10;
  localparam int LO  = 10;
  localparam int HI  = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic frame_stb = 1'b0;
  logic [CW-1:0] width_cfg = CW'(12);
  logic out_pos, out_neg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_neg = 1'b0;   // polarity of previous pulse: 1 = negative

  int n_pos, n_neg, n_both, n_gap;

  always #10 clk = ~clk;

  cc_ami_enc #(.PERIOD_CLKS(PER), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_stb(frame_stb),
    .width_cfg(width_cfg), .out_pos(out_pos), .out_neg(out_neg)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit period; optional width change at cycle chg_at (-1 = none)
  task automatic run_bit(input bit en, input bit stb, input int chg_at,
                         input int chg_val);
    bit seen_low;
    bit_en = en; frame_stb = stb;
    n_pos = 0; n_neg = 0; n_both = 0; n_gap = 0; seen_low = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (i == 0) begin bit_en = 1'b0; frame_stb = 1'b0; end
      if (i == chg_at) width_cfg = CW'(chg_val);
      if (out_pos) n_pos++;
      if (out_neg) n_neg++;
      if (out_pos && out_neg) n_both++;
      if (!out_pos && !out_neg) seen_low = 1;
      else if (seen_low) n_gap++;
    end
  endtask

  task automatic expect_pulse(input string req, input bit neg, input int w);
    check({req, " polarity/width pos"}, n_pos, neg ? 0 : w);
    check({req, " polarity/width neg"}, n_neg, neg ? w : 0);
    check("R8 exclusive", n_both, 0);
    check("R8 low between pulses", n_gap, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset pos", int'(out_pos), 0);
    check("R1 reset neg", int'(out_neg), 0);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 3; k++) begin
      run_bit(1, 0, -1, 0);
      check("R1 idle before strobe", n_pos + n_neg, 0);
    end
  endtask

  task automatic t_stray;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    run_bit(1, 0, -1, 0);
    check("R9 stray strobe does not align", n_pos + n_neg, 0);
  endtask

  task automatic t_octet;
    run_bit(1, 1, -1, 0);
    expect_pulse("R2 first pulse positive", 0, 12);
    check("R5 in-window width", n_pos, 12);
    exp_neg = 0;
    for (int b = 1; b < 8; b++) begin
      run_bit(1, 0, -1, 0);
      exp_neg = !exp_neg;
      expect_pulse("R3 alternation", exp_neg, 12);
    end
    run_bit(1, 1, -1, 0);
    expect_pulse("R4 violation repeats polarity", exp_neg, 12);
    run_bit(1, 0, -1, 0);
    exp_neg = !exp_neg;
    expect_pulse("R4 alternation resumes", exp_neg, 12);
  endtask

  task automatic t_stray_aligned;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    run_bit(1, 0, -1, 0);
    exp_neg = !exp_neg;
    expect_pulse("R9 stray strobe leaves sequence", exp_neg, 12);
  endtask

  task automatic t_width(input int cfg, input int w, input string req);
    width_cfg = CW'(cfg);
    @(negedge clk); @(negedge clk);
    run_bit(1, 0, -1, 0);
    exp_neg = !exp_neg;
    expect_pulse(req, exp_neg, w);
  endtask

  task automatic t_midchange;
    width_cfg = CW'(11);
    @(negedge clk); @(negedge clk);
    run_bit(1, 0, 3, 13);
    exp_neg = !exp_neg;
    expect_pulse("R10 width held during pulse", exp_neg, 11);
    run_bit(1, 0, -1, 0);
    exp_neg = !exp_neg;
    expect_pulse("R10 new width on next pulse", exp_neg, 13);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_stray();
    t_octet();
    t_stray_aligned();
    t_width(LO, LO, "R5 lower limit exact");
    t_width(HI, HI, "R5 upper limit exact");
    t_width(3, LO, "R6 below window clamps");
    t_width(200, HI, "R7 above window clamps");
    t_midchange();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule